// File: doc/BRIEF.md
# Pipelined GF(2^8) Multiplicative Inverter

This block returns the multiplicative inverse of an 8-bit field element in polynomial basis. The reduction polynomial is x^8 + x^4 + x^3 + x + 1. It raises the operand B to the power 2^8 − 2 = 254, which by Fermat's little theorem equals B^-1 for every nonzero B. An operand of zero yields zero.

The exponent is built by a chain of seven identical power-sum stages. Each stage squares its running value first and then multiplies that square by B², so the running exponent grows as 0, 2, 6, 14, 30, 62, 126 and finally 254. Each stage does its field multiplication one partial-product row per clock, with one register slice per row. That gives 8 slices per stage and 56 slices overall. The original operand travels beside the running value, so no stage needs feedback.

The unit accepts a new operand on every clock and delivers each result a fixed 56 cycles later, in input order. A valid strobe travels with every operand. Only the valid path is reset.

Top module: `gf_inverse_pipe`

## Requirements
- R1: An operand sampled with `in_valid` high at the clock edge ending cycle c appears on `out_inv` with `out_valid` high during cycle c+56, exactly.
- R2: For every nonzero operand B, the result R satisfies R·B = 1 in GF(2^8). Products are reduced by 0x11B (x^8+x^4+x^3+x+1), and bit i of a byte is the coefficient of x^i.
- R3: An operand of 0x00 produces a result of 0x00.
- R4: Operands presented on consecutive cycles produce results on consecutive cycles, in the same order, with no lost or repeated result.
- R5: A cycle with `in_valid` low produces a cycle with `out_valid` low 56 cycles later, whatever value `in_elem` holds.
- R6: While `rst_n` (synchronous, active-low) is low at a clock edge, all operands in flight are discarded and nothing is captured. `out_valid` then stays low until an operand accepted after the release has crossed the full latency.
- R7: Every stage computes X²·B² with the squaring ahead of the multiplication. After seven stages the result equals B^254.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid path |
| in_valid | input | 1 | Marks `in_elem` as an operand to be inverted this cycle |
| in_elem | input | 8 | Field element to invert, polynomial basis |
| out_valid | output | 1 | Marks `out_inv` as a result this cycle |
| out_inv | output | 8 | Inverse of the operand accepted 56 cycles earlier |

## Verification
The assertions assume that `rst_n` is held low across the first clock edge. They also assume that `in_elem` carries a known value whenever `in_valid` is high, because the product check multiplies the operand carried to the output by the result. The bench always starts in reset and drives only defined bytes. When `in_valid` is low it also drives deliberately meaningless but defined bytes, so that R5 is exercised without feeding unknown values into the data path. Reset is asserted again while operands are in flight, which tests the discard rule and the in-flight accounting that the checker keeps.

// File: rtl/gf_inv_pkg.sv
// Package gf_inv_pkg
// Holds the field constants and the combinational field helpers that the
// inverter pipeline and its checker share. Assumes polynomial basis, with
// bit i of an element as the coefficient of x^i.
package gf_inv_pkg;

    localparam int          FIELD_W    = 8;
    localparam logic [8:0]  FIELD_POLY = 9'h11B;
    localparam int          ROW_SLICES = FIELD_W;
    localparam int          AB2_STAGES = FIELD_W - 1;
    localparam int          PIPE_DEPTH = AB2_STAGES * ROW_SLICES;

    typedef logic [FIELD_W-1:0] gf_elem_t;

    // Multiply by x and reduce once.
    function automatic gf_elem_t gf_xtime(input gf_elem_t a);
        logic [FIELD_W:0] t;
        t = {a, 1'b0};
        if (t[FIELD_W]) begin
            t = t ^ FIELD_POLY;
        end
        return t[FIELD_W-1:0];
    endfunction

    // Square: spread the bits to even positions, then fold down the high part.
    function automatic gf_elem_t gf_square(input gf_elem_t a);
        logic [2*FIELD_W-2:0] s;
        s = '0;
        for (int i = 0; i < FIELD_W; i++) begin
            s[2*i] = a[i];
        end
        for (int k = 2*FIELD_W-2; k >= FIELD_W; k--) begin
            if (s[k]) begin
                s[k -: FIELD_W+1] = s[k -: FIELD_W+1] ^ FIELD_POLY;
            end
        end
        return s[FIELD_W-1:0];
    endfunction

    // Full multiplier, MSB-first shift and add (used by the checker only).
    function automatic gf_elem_t gf_mul(input gf_elem_t a, input gf_elem_t b);
        gf_elem_t acc;
        acc = '0;
        for (int i = FIELD_W-1; i >= 0; i--) begin
            acc = gf_xtime(acc) ^ (b[i] ? a : '0);
        end
        return acc;
    endfunction

endpackage

// File: rtl/gf_row_slice.sv
// Module gf_row_slice
// One register slice of a bit-serial-by-row field multiplier. It handles a
// single partial-product row: the accumulator is multiplied by x and the
// multiplicand is added when the selected multiplier bit is set. Operands are
// passed on unchanged so that the next slice needs no feedback.
// Assumes rows are walked MSB first: ROW 0 uses multiplier bit FIELD_W-1.
module gf_row_slice
    import gf_inv_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic     clk,
    input  gf_elem_t acc_i,
    input  gf_elem_t mcand_i,
    input  gf_elem_t mplier_i,
    input  gf_elem_t orig_i,
    output gf_elem_t acc_o,
    output gf_elem_t mcand_o,
    output gf_elem_t mplier_o,
    output gf_elem_t orig_o
);

    localparam int BIT_SEL = FIELD_W - 1 - ROW;

    gf_elem_t acc_next;

    // Partial-product row: shift accumulator and add selected multiplicand.
    always_comb begin
        acc_next = gf_xtime(acc_i) ^ (mplier_i[BIT_SEL] ? mcand_i : '0);
    end

    // Slice register; data is not reset, the valid path tracks it instead.
    always_ff @(posedge clk) begin
        acc_o    <= acc_next;
        mcand_o  <= mcand_i;
        mplier_o <= mplier_i;
        orig_o   <= orig_i;
    end

endmodule

// File: rtl/gf_ab2_stage.sv
// Module gf_ab2_stage
// One square-first power-sum stage. It squares the running value X and the
// carried operand B, then multiplies the two squares over ROW_SLICES register
// slices, giving X^2 * B^2 after ROW_SLICES cycles. The original B leaves
// alongside the result for the next stage.
// Assumes x_i and orig_i belong to the same operand in the same cycle.
module gf_ab2_stage
    import gf_inv_pkg::*;
(
    input  logic     clk,
    input  gf_elem_t x_i,
    input  gf_elem_t orig_i,
    output gf_elem_t x_o,
    output gf_elem_t orig_o
);

    gf_elem_t acc_w    [ROW_SLICES+1];
    gf_elem_t mcand_w  [ROW_SLICES+1];
    gf_elem_t mplier_w [ROW_SLICES+1];
    gf_elem_t orig_w   [ROW_SLICES+1];

    // Square-first front end: both factors are squared before any row work.
    always_comb begin
        acc_w[0]    = '0;
        mcand_w[0]  = gf_square(x_i);
        mplier_w[0] = gf_square(orig_i);
        orig_w[0]   = orig_i;
    end

    for (genvar r = 0; r < ROW_SLICES; r++) begin : g_row
        gf_row_slice #(
            .ROW (r)
        ) row_i (
            .clk      (clk),
            .acc_i    (acc_w[r]),
            .mcand_i  (mcand_w[r]),
            .mplier_i (mplier_w[r]),
            .orig_i   (orig_w[r]),
            .acc_o    (acc_w[r+1]),
            .mcand_o  (mcand_w[r+1]),
            .mplier_o (mplier_w[r+1]),
            .orig_o   (orig_w[r+1])
        );
    end

    // Stage outputs: finished product and the operand that produced it.
    always_comb begin
        x_o    = acc_w[ROW_SLICES];
        orig_o = orig_w[ROW_SLICES];
    end

endmodule

// File: rtl/gf_valid_pipe.sv
// Module gf_valid_pipe
// Shift register that carries the valid strobe in lockstep with the data
// slices. A synchronous active-low reset clears every bit, which discards
// anything in flight.
// Assumes DEPTH is at least 2.
module gf_valid_pipe #(
    parameter int DEPTH = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    output logic vld_o
);

    logic [DEPTH-1:0] vld_sr;

    // Advance the valid strobe one slice per clock; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[DEPTH-2:0], vld_i};
        end
    end

    // Last slice drives the output strobe.
    always_comb begin
        vld_o = vld_sr[DEPTH-1];
    end

endmodule

// File: rtl/gf_inverse_pipe.sv
// Module gf_inverse_pipe
// Fully pipelined inverter: B^-1 = B^(2^W - 2) computed by AB2_STAGES chained
// square-first stages, starting from X = 1, each producing X^2 * B^2. One
// operand per clock; fixed PIPE_DEPTH cycle latency; zero maps to zero.
// Assumes no backpressure; the consumer takes every result as it appears.
module gf_inverse_pipe
    import gf_inv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_elem,
    output logic       out_valid,
    output logic [7:0] out_inv
);

    gf_elem_t stage_x [AB2_STAGES+1];
    gf_elem_t stage_b [AB2_STAGES+1];
    gf_elem_t fin_orig;

    // Chain head: running value starts at one, operand enters unregistered.
    always_comb begin
        stage_x[0] = gf_elem_t'(1);
        stage_b[0] = in_elem;
    end

    for (genvar s = 0; s < AB2_STAGES; s++) begin : g_stage
        gf_ab2_stage stage_i (
            .clk    (clk),
            .x_i    (stage_x[s]),
            .orig_i (stage_b[s]),
            .x_o    (stage_x[s+1]),
            .orig_o (stage_b[s+1])
        );
    end

    gf_valid_pipe #(
        .DEPTH (PIPE_DEPTH)
    ) vld_i (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (in_valid),
        .vld_o (out_valid)
    );

    // Result and the operand it belongs to, seen at the chain tail.
    always_comb begin
        out_inv  = stage_x[AB2_STAGES];
        fin_orig = stage_b[AB2_STAGES];
    end

endmodule

// File: rtl/gf_inverse_pipe_chk.sv
// Module gf_inverse_pipe_chk
// Property checker bound to gf_inverse_pipe. It keeps its own count of the
// operands in flight and of the cycles since reset, and checks each result
// against the operand carried beside it to the chain tail.
// Assumes rst_n is low at the first clock edge.
module gf_inverse_pipe_chk
    import gf_inv_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     in_valid,
    input logic     out_valid,
    input gf_elem_t out_inv,
    input gf_elem_t fin_orig
);

    localparam int CW = $clog2(PIPE_DEPTH + 1) + 1;

    logic [CW-1:0] inflight;
    logic [CW-1:0] since_rst;

    // Operands accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            case ({in_valid, out_valid})
                2'b10:   inflight <= inflight + 1'b1;
                2'b01:   inflight <= inflight - 1'b1;
                default: inflight <= inflight;
            endcase
        end
    end

    // Cycles since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst < CW'(PIPE_DEPTH)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R6
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(PIPE_DEPTH)) |-> !out_valid);

    // R1
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(PIPE_DEPTH));

    // R4
    no_orphan_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));

    // R2
    inverse_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fin_orig != '0) |-> (gf_mul(fin_orig, out_inv) == gf_elem_t'(1)));

    // R3
    zero_maps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fin_orig == '0) |-> (out_inv == '0));

endmodule

bind gf_inverse_pipe gf_inverse_pipe_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_inv   (out_inv),
    .fin_orig  (fin_orig)
);

// File: tb/gf_inverse_pipe_tb_top.sv
module gf_inverse_pipe_tb_top;

    localparam int LAT      = 56;
    localparam int SLOTS    = 128;
    localparam int WD_LIMIT = 20000;
    localparam int NVEC     = 5;
    // {operand, expected inverse}
    localparam logic [15:0] VEC [NVEC] = '{16'h0101, 16'h028D, 16'h03F6, 16'h53CA, 16'h0000};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_elem = 8'h00;
    logic       out_valid;
    logic [7:0] out_inv;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    bit         exp_v   [SLOTS];
    logic [7:0] exp_d   [SLOTS];
    logic [7:0] exp_in  [SLOTS];
    string      exp_tag [SLOTS];

    gf_inverse_pipe dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_elem   (in_elem),
        .out_valid (out_valid),
        .out_inv   (out_inv)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] ref_inv(input logic [7:0] b);
        logic [7:0] r = 8'h00;
        for (int c = 1; c < 256; c++) begin
            if (ref_mul(b, 8'(c)) == 8'h01) r = 8'(c);
        end
        return r;
    endfunction

    // Drive one cycle and record what must appear LAT cycles later.
    task automatic drive(input bit v, input logic [7:0] d, input logic [7:0] e, input string tag);
        int slot;
        slot = (cyc + LAT) % SLOTS;
        in_valid = v;
        in_elem  = d;
        exp_v[slot]   = v;
        exp_d[slot]   = e;
        exp_in[slot]  = d;
        exp_tag[slot] = tag;
        @(negedge clk);
    endtask

    task automatic apply_reset(input int n);
        int keep;
        keep = cyc % SLOTS;
        for (int s = 0; s < SLOTS; s++) begin
            if (s != keep) begin
                exp_v[s]   = 1'b0;
                exp_tag[s] = "R6";
            end
        end
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_elem  = 8'h5A;
        repeat (n) @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
    endtask

    // Monitor: compare outputs of this cycle with the recorded expectation.
    always @(negedge clk) begin
        if (mon_on) begin
            int slot;
            slot = cyc % SLOTS;
            checks++;
            if (exp_v[slot]) begin
                if (out_valid !== 1'b1) begin
                    failures++;
                    $display("FAIL R1 cycle %0d out_valid actual=%b expected=1", cyc, out_valid);
                end else if (out_inv !== exp_d[slot]) begin
                    failures++;
                    $display("FAIL %s cycle %0d in=%h out_inv actual=%h expected=%h",
                             exp_tag[slot], cyc, exp_in[slot], out_inv, exp_d[slot]);
                end else if (exp_in[slot] != 8'h00) begin
                    checks++;
                    if (ref_mul(out_inv, exp_in[slot]) != 8'h01) begin
                        failures++;
                        $display("FAIL R2 cycle %0d product actual=%h expected=01",
                                 cyc, ref_mul(out_inv, exp_in[slot]));
                    end
                end
            end else if (out_valid !== 1'b0) begin
                failures++;
                $display("FAIL %s cycle %0d out_valid actual=%b expected=0",
                         exp_tag[slot], cyc, out_valid);
            end
            exp_v[slot]   = 1'b0;
            exp_tag[slot] = "R5";
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        if (!done && cyc > WD_LIMIT) begin
            failures++;
            $display("FAIL R1 watchdog cycles actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SLOTS; s++) begin
            exp_v[s]   = 1'b0;
            exp_tag[s] = "R6";
        end
        repeat (4) @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;   // R6: outputs must stay quiet after release

        // R2 / R3 / R7: table of known inverses, back to back.
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VEC[i][15:8], VEC[i][7:0], (VEC[i][15:8] == 8'h00) ? "R3" : "R7");
        end

        // R5: idle with changing garbage on the data input.
        for (int i = 0; i < 60; i++) begin
            drive(1'b0, 8'(i * 37 + 11), 8'h00, "R5");
        end

        // R4 / R2: every element, back to back.
        for (int i = 0; i < 256; i++) begin
            drive(1'b1, 8'(i), ref_inv(8'(i)), "R4");
        end

        // R1 / R5: sparse pattern.
        for (int i = 0; i < 24; i++) begin
            drive(i % 3 == 0, 8'(255 - i * 5), ref_inv(8'(255 - i * 5)), (i % 3 == 0) ? "R1" : "R5");
        end

        // R6: reset while operands are in flight.
        for (int i = 0; i < 30; i++) begin
            drive(1'b1, 8'(i + 100), ref_inv(8'(i + 100)), "R1");
        end
        apply_reset(3);
        repeat (LAT + 10) drive(1'b0, 8'hC3, 8'h00, "R6");

        // R1: single operand after the reset.
        drive(1'b1, 8'h02, 8'h8D, "R1");
        repeat (LAT + 6) drive(1'b0, 8'h00, 8'h00, "R5");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule